// File: doc/BRIEF.md
# Configurable LRU Group Arbiter

This block decides which of four request groups may use one shared downstream memory port. The groups are labelled 2, 3, 4 and 5 and map to internal indices 0 to 3. A group that wins holds the grant while a stream of per-service completion strobes arrives. Its grant sequence ends after a set number of services, or earlier if its request has gone away. The block then re-arbitrates.

By default the groups are ranked by recency, so the group served longest ago wins. A single 32-bit configuration register changes this in three ways. It can give one group absolute precedence. It can set how many consecutive services each group gets once it wins. It can make a group's request wait until that group reports a whole burst buffered. The register is written through a simple write strobe and is always visible on a read-back bus.

Top module: `lru_group_arbiter`

## Requirements
- R1: After reset no grant is driven (grantOneHot = 0) and cfgRdData reads 0x00055000. Every group has a run length of 1, no group has precedence and no group has burst gating.
- R2: For group k (2..5), the burst-gating bit is cfg bit 24+k, the run-length field is cfg bits 2k+9:2k+8 and the precedence bit is cfg bit k. Writing 0xFFFFFFFF reads back 0x3C0FF03C, and all other bits always read 0.
- R3: A group is eligible when its reqValid bit is 1 and either its burst-gating bit is 0 or its burstReady bit is 1. A gated group without burstReady is never granted.
- R4: A grant is registered on the clock edge after the idle cycle in which an eligible group is seen. grantOneHot has exactly bit (k-2) set for group k, and grantIdx equals k-2.
- R5: Among eligible groups without precedence, the least recently served one wins. Right after reset the order from least to most recent is group 2, 3, 4, 5. A group becomes most recent when its grant sequence ends.
- R6: An eligible group with its precedence bit set wins over every other group. If several flagged groups are eligible, the lowest-numbered one wins.
- R7: While a grant is held, grantOneHot and grantIdx do not change on any cycle in which serviceDone is 0.
- R8: A group with run length N (1..3) keeps the grant through N serviceDone strobes, and a field value of 0 counts as 1. The grant drops at the edge that samples the final strobe, and the next grant can appear one edge later.
- R9: If the granted group is not eligible when serviceDone is sampled, its grant sequence ends at that edge, even if services remain.
- R10: When no group is eligible and no grant is held, grantOneHot stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 4 | Request valid per group, bit 0 = group 2 |
| burstReady | input | 4 | Whole burst buffered, per group |
| serviceDone | input | 1 | One service of the current grant completed |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 32 | Configuration write data |
| cfgRdData | output | 32 | Configuration read-back |
| grantOneHot | output | 4 | One-hot grant, bit 0 = group 2 |
| grantIdx | output | 2 | Index of the granted group (group number minus 2) |

## Verification
Several properties are checked on every cycle: the grant is one-hot with a matching index, and it holds steady without a completion strobe. A grant never switches directly from one group to another. It never goes to an ineligible group and never appears when nothing is eligible. A flagged group always wins a fresh arbitration, early release happens when the owner has stopped requesting, and reserved bits stay zero. The recency order over a long run, the exact number of services in each run length, and the release of a gated request once its burst is ready all depend on history. Only the bench's scoreboard scenarios, which model the order independently, can show them.

// File: rtl/arb_pkg.sv
package arb_pkg;

  localparam int NUM_GRP   = 4;
  localparam int CNT_W     = 2;
  localparam int REG_W     = 32;
  localparam int BC_LSB    = 26;
  localparam int EXT_LSB   = 12;
  localparam int HP_LSB    = 2;

  // control -> datapath strobes
  typedef struct packed {
    logic loadGrant;
    logic nextService;
    logic endSeq;
  } ctrlStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic anyEligible;
    logic lastService;
    logic curEligible;
  } dpStatus_t;

endpackage

// File: rtl/arb_lru_order.sv
module arb_lru_order #(
  parameter int NUM_GRP = arb_pkg::NUM_GRP,
  localparam int IDX_W  = $clog2(NUM_GRP)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               touchEn,
  input  logic [IDX_W-1:0]   touchIdx,
  input  logic [NUM_GRP-1:0] eligible,
  output logic [IDX_W-1:0]   pickIdx
);

  // orderQ[0] is least recently served, orderQ[NUM_GRP-1] most recent
  logic [IDX_W-1:0] orderQ [NUM_GRP];
  logic [IDX_W-1:0] orderD [NUM_GRP];

  always_comb begin
    pickIdx = '0;
    for (int p = NUM_GRP - 1; p >= 0; p--) begin
      if (eligible[orderQ[p]]) pickIdx = orderQ[p];
    end
  end

  always_comb begin
    int j;
    j = 0;
    for (int p = 0; p < NUM_GRP; p++) orderD[p] = orderQ[p];
    if (touchEn) begin
      for (int p = 0; p < NUM_GRP; p++) begin
        if (orderQ[p] != touchIdx) begin
          orderD[j] = orderQ[p];
          j = j + 1;
        end
      end
      orderD[NUM_GRP-1] = touchIdx;
    end
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < NUM_GRP; p++) begin
      if (!rstN) orderQ[p] <= IDX_W'(p);
      else       orderQ[p] <= orderD[p];
    end
  end

endmodule

// File: rtl/arb_datapath.sv
module arb_datapath
  import arb_pkg::*;
#(
  parameter int NUM_GRP = arb_pkg::NUM_GRP,
  parameter int CNT_W   = arb_pkg::CNT_W,
  localparam int IDX_W  = $clog2(NUM_GRP),
  localparam int EXT_W  = NUM_GRP * CNT_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobe_t        strobe,
  input  logic [NUM_GRP-1:0] reqValid,
  input  logic [NUM_GRP-1:0] burstReady,
  input  logic               cfgWrEn,
  input  logic [REG_W-1:0]   cfgWrData,
  output logic [REG_W-1:0]   cfgRdData,
  output dpStatus_t          status,
  output logic [NUM_GRP-1:0] grantOneHot,
  output logic [IDX_W-1:0]   grantIdx
);

  localparam logic [CNT_W-1:0] ONE_SVC = CNT_W'(1);
  localparam logic [REG_W-1:0] WR_MASK =
      (REG_W'({NUM_GRP{1'b1}}) << BC_LSB) |
      (REG_W'({EXT_W{1'b1}})   << EXT_LSB) |
      (REG_W'({NUM_GRP{1'b1}}) << HP_LSB);
  localparam logic [REG_W-1:0] CFG_RST =
      REG_W'({NUM_GRP{ONE_SVC}}) << EXT_LSB;

  logic [REG_W-1:0]   cfgQ;
  logic [NUM_GRP-1:0] gateMask;
  logic [NUM_GRP-1:0] prioMask;
  logic [EXT_W-1:0]   extField;
  logic [NUM_GRP-1:0] eligible;
  logic [NUM_GRP-1:0] prioHit;
  logic [IDX_W-1:0]   prioIdx;
  logic [IDX_W-1:0]   lruIdx;
  logic [IDX_W-1:0]   winIdx;
  logic [CNT_W-1:0]   winLen;
  logic               grantValidQ;
  logic [IDX_W-1:0]   grantIdxQ;
  logic [CNT_W-1:0]   svcLeftQ;

  // configuration register
  always_ff @(posedge clk) begin
    if (!rstN)        cfgQ <= CFG_RST;
    else if (cfgWrEn) cfgQ <= cfgWrData & WR_MASK;
  end

  assign cfgRdData = cfgQ;
  assign gateMask  = cfgQ[BC_LSB +: NUM_GRP];
  assign prioMask  = cfgQ[HP_LSB +: NUM_GRP];
  assign extField  = cfgQ[EXT_LSB +: EXT_W];

  // eligibility per group
  genvar g;
  generate
    for (g = 0; g < NUM_GRP; g++) begin : g_elig
      assign eligible[g] = reqValid[g] & (~gateMask[g] | burstReady[g]);
    end
  endgenerate

  assign prioHit = eligible & prioMask;

  always_comb begin
    prioIdx = '0;
    for (int k = NUM_GRP - 1; k >= 0; k--) begin
      if (prioHit[k]) prioIdx = IDX_W'(k);
    end
  end

  arb_lru_order #(.NUM_GRP(NUM_GRP)) u_order (
    .clk      (clk),
    .rstN     (rstN),
    .touchEn  (strobe.endSeq),
    .touchIdx (grantIdxQ),
    .eligible (eligible),
    .pickIdx  (lruIdx)
  );

  assign winIdx = (|prioHit) ? prioIdx : lruIdx;

  always_comb begin
    winLen = extField[winIdx * CNT_W +: CNT_W];
    if (winLen == '0) winLen = ONE_SVC;
  end

  // grant state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantValidQ <= 1'b0;
      grantIdxQ   <= '0;
      svcLeftQ    <= '0;
    end else if (strobe.loadGrant) begin
      grantValidQ <= 1'b1;
      grantIdxQ   <= winIdx;
      svcLeftQ    <= winLen;
    end else if (strobe.endSeq) begin
      grantValidQ <= 1'b0;
    end else if (strobe.nextService) begin
      svcLeftQ    <= svcLeftQ - ONE_SVC;
    end
  end

  generate
    for (g = 0; g < NUM_GRP; g++) begin : g_onehot
      assign grantOneHot[g] = grantValidQ && (grantIdxQ == IDX_W'(g));
    end
  endgenerate

  assign grantIdx           = grantIdxQ;
  assign status.anyEligible = |eligible;
  assign status.lastService = (svcLeftQ == ONE_SVC);
  assign status.curEligible = eligible[grantIdxQ];

endmodule

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        serviceDone,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe
);

  typedef enum logic {ST_IDLE, ST_BUSY} arbState_t;

  arbState_t stateQ;
  arbState_t stateD;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    case (stateQ)
      ST_IDLE: begin
        if (status.anyEligible) begin
          strobe.loadGrant = 1'b1;
          stateD           = ST_BUSY;
        end
      end
      ST_BUSY: begin
        if (serviceDone) begin
          if (status.lastService || !status.curEligible) begin
            strobe.endSeq = 1'b1;
            stateD        = ST_IDLE;
          end else begin
            strobe.nextService = 1'b1;
          end
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

endmodule

// File: rtl/lru_group_arbiter.sv
module lru_group_arbiter
  import arb_pkg::*;
#(
  parameter int NUM_GRP = arb_pkg::NUM_GRP,
  parameter int CNT_W   = arb_pkg::CNT_W,
  localparam int IDX_W  = $clog2(NUM_GRP)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_GRP-1:0] reqValid,
  input  logic [NUM_GRP-1:0] burstReady,
  input  logic               serviceDone,
  input  logic               cfgWrEn,
  input  logic [REG_W-1:0]   cfgWrData,
  output logic [REG_W-1:0]   cfgRdData,
  output logic [NUM_GRP-1:0] grantOneHot,
  output logic [IDX_W-1:0]   grantIdx
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;

  arb_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .serviceDone (serviceDone),
    .status      (status),
    .strobe      (strobe)
  );

  arb_datapath #(.NUM_GRP(NUM_GRP), .CNT_W(CNT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqValid    (reqValid),
    .burstReady  (burstReady),
    .cfgWrEn     (cfgWrEn),
    .cfgWrData   (cfgWrData),
    .cfgRdData   (cfgRdData),
    .status      (status),
    .grantOneHot (grantOneHot),
    .grantIdx    (grantIdx)
  );

endmodule

// File: rtl/arb_checker.sv
module arb_checker
  import arb_pkg::*;
#(
  parameter int NUM_GRP = arb_pkg::NUM_GRP,
  localparam int IDX_W  = $clog2(NUM_GRP)
) (
  input logic               clk,
  input logic               rstN,
  input logic [NUM_GRP-1:0] reqValid,
  input logic [NUM_GRP-1:0] burstReady,
  input logic               serviceDone,
  input logic [REG_W-1:0]   cfgRdData,
  input logic [NUM_GRP-1:0] grantOneHot,
  input logic [IDX_W-1:0]   grantIdx
);

  localparam logic [REG_W-1:0] RSVD_MASK = ~(
      (REG_W'({NUM_GRP{1'b1}}) << BC_LSB) |
      (REG_W'({(NUM_GRP*CNT_W){1'b1}}) << EXT_LSB) |
      (REG_W'({NUM_GRP{1'b1}}) << HP_LSB));

  logic [NUM_GRP-1:0] eligObs;
  logic [NUM_GRP-1:0] hpObs;
  logic [NUM_GRP-1:0] hpLow;

  assign eligObs = reqValid & (~cfgRdData[BC_LSB +: NUM_GRP] | burstReady);
  assign hpObs   = eligObs & cfgRdData[HP_LSB +: NUM_GRP];

  always_comb begin
    hpLow = '0;
    for (int k = NUM_GRP - 1; k >= 0; k--) begin
      if (hpObs[k]) hpLow = NUM_GRP'(1) << k;
    end
  end

  p_onehot_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantOneHot));

  p_idx_match_r4: assert property (@(posedge clk) disable iff (!rstN)
    (grantOneHot != '0) |-> grantOneHot[grantIdx]);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (grantOneHot != '0 && !serviceDone) |=> (grantOneHot == $past(grantOneHot)));

  p_no_switch_r8: assert property (@(posedge clk) disable iff (!rstN)
    (grantOneHot != '0) |=> (grantOneHot == '0 || grantOneHot == $past(grantOneHot)));

  p_eligible_r3: assert property (@(posedge clk) disable iff (!rstN)
    (grantOneHot == '0) |=> (grantOneHot == '0 || (grantOneHot & $past(eligObs)) != '0));

  p_idle_r10: assert property (@(posedge clk) disable iff (!rstN)
    (grantOneHot == '0 && eligObs == '0) |=> (grantOneHot == '0));

  p_prio_r6: assert property (@(posedge clk) disable iff (!rstN)
    (grantOneHot == '0 && hpObs != '0) |=> (grantOneHot == $past(hpLow)));

  p_early_r9: assert property (@(posedge clk) disable iff (!rstN)
    (grantOneHot != '0 && serviceDone && (grantOneHot & eligObs) == '0) |=> (grantOneHot == '0));

  p_rsvd_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((cfgRdData & RSVD_MASK) == '0));

endmodule

bind lru_group_arbiter arb_checker #(.NUM_GRP(NUM_GRP)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .burstReady  (burstReady),
  .serviceDone (serviceDone),
  .cfgRdData   (cfgRdData),
  .grantOneHot (grantOneHot),
  .grantIdx    (grantIdx)
);

// File: tb/lru_group_arbiter_test.sv
module lru_group_arbiter_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  req = '0;
  logic [3:0]  burst = '0;
  logic        done = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [3:0]  gnt;
  logic [1:0]  gidx;

  int compared = 0;
  int mismatched = 0;
  int    expIdxQ[$];
  string expTagQ[$];
  int    lruQ[$];
  logic [3:0] prevGnt = '0;

  always #5 clk = ~clk;

  lru_group_arbiter uut (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (req),
    .burstReady  (burst),
    .serviceDone (done),
    .cfgWrEn     (wrEn),
    .cfgWrData   (wrData),
    .cfgRdData   (rdData),
    .grantOneHot (gnt),
    .grantIdx    (gidx)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic pushExp(int idx, string tag);
    expIdxQ.push_back(idx);
    expTagQ.push_back(tag);
  endtask

  function automatic int pickLru(logic [3:0] m);
    foreach (lruQ[i]) if (m[lruQ[i]]) return lruQ[i];
    return -1;
  endfunction

  task automatic retire(int idx);
    foreach (lruQ[i]) begin
      if (lruQ[i] == idx) begin
        lruQ.delete(i);
        break;
      end
    end
    lruQ.push_back(idx);
  endtask

  task automatic waitGrant();
    do @(negedge clk); while (gnt == '0);
  endtask

  task automatic pulseDone();
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
  endtask

  task automatic writeCfg(logic [31:0] d);
    wrEn = 1'b1;
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // monitor: each fresh grant is compared with the head of the scoreboard
  always @(posedge clk) begin
    #1;
    if (rstN) begin
      if (gnt != '0 && prevGnt == '0) begin
        compared++;
        if (expIdxQ.size() == 0) begin
          mismatched++;
          $display("FAIL R4 unexpected grant: got idx %0d expected none", gidx);
        end else begin
          int e;
          string t;
          e = expIdxQ.pop_front();
          t = expTagQ.pop_front();
          if (gidx != 2'(e) || gnt != (4'b0001 << e)) begin
            mismatched++;
            $display("FAIL %s/R4 grant: got idx %0d onehot 0x%0h expected idx %0d",
                     t, gidx, gnt, e);
          end
        end
      end
      prevGnt = gnt;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    lruQ = '{0, 1, 2, 3};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset grant", 32'(gnt), 32'h0);
    check("R1 reset cfg", rdData, 32'h0005_5000);

    // R2 field positions and reserved bits
    writeCfg(32'hFFFF_FFFF);
    check("R2 readback all ones", rdData, 32'h3C0F_F03C);
    writeCfg(32'h0005_5000);
    check("R2 readback default", rdData, 32'h0005_5000);

    // R5 recency rotation, all groups eligible (R3 with gating off)
    req = 4'hF;
    for (int i = 0; i < 5; i++) begin
      int e;
      e = pickLru(req);
      pushExp(e, "R5 lru");
      waitGrant();
      pulseDone();
      retire(e);
    end
    req = '0;
    repeat (3) begin
      @(negedge clk);
      check("R10 idle", 32'(gnt), 32'h0);
    end

    // R8 run length 3 for group 3, run length 0 for group 4
    writeCfg(32'h0004_D000);
    req = 4'b0010;
    pushExp(1, "R8 len3");
    waitGrant();
    repeat (3) @(negedge clk);
    check("R7 held without done", 32'(gnt), 32'h2);
    pulseDone();
    check("R8 held after 1 of 3", 32'(gnt), 32'h2);
    pulseDone();
    check("R8 held after 2 of 3", 32'(gnt), 32'h2);
    pulseDone();
    check("R8 released after 3", 32'(gnt), 32'h0);
    req = '0;
    retire(1);

    req = 4'b0100;
    pushExp(2, "R8 len0");
    waitGrant();
    pulseDone();
    check("R8 zero means one", 32'(gnt), 32'h0);
    req = '0;
    retire(2);

    // R6 precedence for group 4
    writeCfg(32'h0004_D010);
    req = 4'hF;
    for (int i = 0; i < 2; i++) begin
      pushExp(2, "R6 prio");
      waitGrant();
      pulseDone();
      retire(2);
    end
    req = '0;

    // R6 two flags, R9 early release
    writeCfg(32'h0005_9028);
    check("R2 readback mixed", rdData, 32'h0005_9028);
    req = 4'hF;
    pushExp(1, "R6 lowest flag");
    waitGrant();
    req = 4'b1101;
    pulseDone();
    check("R9 early release", 32'(gnt), 32'h0);
    retire(1);
    pushExp(3, "R6 remaining flag");
    waitGrant();
    pulseDone();
    req = '0;
    retire(3);

    // R3 burst gating for group 2
    writeCfg(32'h0405_5000);
    burst = '0;
    req = 4'b0001;
    repeat (4) begin
      @(negedge clk);
      check("R3 gated", 32'(gnt), 32'h0);
    end
    burst = 4'b0001;
    pushExp(pickLru(4'b0001), "R3 burst ready");
    waitGrant();
    pulseDone();
    req = '0;
    burst = '0;

    repeat (3) @(negedge clk);
    check("R4 scoreboard drained", 32'(expIdxQ.size()), 32'h0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule